// File: doc/BRIEF.md
# Laser Transmit Disable and Fault Latch

This block holds the digital safety control of an optical transmitter. A hardware disable pin and a software disable bit are combined into one effective disable, and the laser enable output follows from it. A laser fault reported by the analog side latches an active-high fault output and forces the laser off, whatever the disable inputs say. The latch is released only by reset, or by the host driving the hardware disable pin high and then low again. The rising edge of that cycle must come a minimum spacing after the previous rising edge of the pin.

Both raw inputs are asynchronous and pass through two-flop synchronizers. One control/status byte is read and written through a plain register port. Only the software disable bit in that byte can be written. The effective disable state and the latched fault are mirrored into the byte as read-only bits. Between resets the synchronized pin is taken as high, so the laser stays off until the host drives the pin low.

Top module: `laser_guard`

## Requirements
- R1: `laserEnable` is 0 while the synchronized hardware disable pin is high. With no fault latched and software disable clear, `laserEnable` is 1 while the pin is low.
- R2: A write puts `regWrData[6]` into the software disable bit. This bit is ORed with the pin to form the effective disable, so a 1 turns the laser off.
- R3: `regRdData[7]` reads the effective disable (pin OR software bit). `regRdData[6]` reads the software bit. Bits 5..3 and 1..0 read 0.
- R4: A synchronized high on `faultDetectIn` sets the fault latch. It drives `txFaultOut` high (1 = fault, 0 = normal) and forces `laserEnable` to 0.
- R5: The fault stays latched after `faultDetectIn` returns low and while the software bit is written. Only R6 or reset clears it.
- R6: A rising edge of the synchronized pin seen while the fault is latched arms a clear. The following falling edge clears the fault.
- R7: Reset sets the software bit to 0 and the fault latch to 0, and takes the pin as high. Right after reset `laserEnable` is 0 and `regRdData` reads 8'h80.
- R8: A rising edge of the pin less than `SPACING_CYCLES` clock cycles after the previous rising edge does not arm a clear.
- R9: Writes change only bit 6. Writing 1 to bits 7 and 2 does not set the monitor or the fault.
- R10: If the fault input is high in the cycle of the clearing falling edge, the fault stays latched.
- R11: `regRdData[2]` reads the latched fault state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwDisableIn | input | 1 | Asynchronous hardware disable pin, high disables |
| faultDetectIn | input | 1 | Asynchronous raw laser fault detect, high = fault |
| regWrEn | input | 1 | Write strobe for the control/status byte |
| regWrData | input | 8 | Write data, only bit 6 is used |
| regRdData | output | 8 | Control/status byte readback |
| laserEnable | output | 1 | Laser drive enable |
| txFaultOut | output | 1 | Latched fault output |

## Verification
The bench checks that the fault outlives its cause, both software toggling and raw input toggling. A latch that follows its input, or that clears on a software write, would drop `txFaultOut` early. A pin toggle issued too soon after the previous one must leave the fault set, so a design without the spacing counter would clear it. A fault present on the clearing falling edge must win, so a design that gives clear priority would release the laser. The bench also writes all ones to the byte to show that the monitor and fault bits cannot be forced, and checks that reset starts in the disabled state.

// File: rtl/laser_guard_pkg.sv
package laser_guard_pkg;
  localparam int BIT_MON   = 7;
  localparam int BIT_SWDIS = 6;
  localparam int BIT_FAULT = 2;

  typedef struct packed {
    logic setFault;
    logic clrFault;
    logic hwDis;
  } guardStrobes_t;
endpackage

// File: rtl/laser_guard_ctrl.sv
module laser_guard_ctrl
  import laser_guard_pkg::*;
#(
  parameter int SPACING_CYCLES = 1250000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hwDisableIn,
  input  logic          faultDetectIn,
  input  logic          faultLatched,
  output guardStrobes_t strobes
);
  localparam int CNT_W = $clog2(SPACING_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SPACING_CYCLES);

  logic [SYNC_STAGES-1:0] hwSyncQ;
  logic [SYNC_STAGES-1:0] faultSyncQ;
  logic                   hwPrev;
  logic [CNT_W-1:0]       gapCnt;
  logic                   armed;
  logic                   hwS, faultS, hwRise, hwFall, gapDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwSyncQ    <= '1;
      faultSyncQ <= '0;
    end else begin
      hwSyncQ    <= {hwSyncQ[SYNC_STAGES-2:0], hwDisableIn};
      faultSyncQ <= {faultSyncQ[SYNC_STAGES-2:0], faultDetectIn};
    end
  end

  assign hwS     = hwSyncQ[SYNC_STAGES-1];
  assign faultS  = faultSyncQ[SYNC_STAGES-1];
  assign hwRise  = hwS & ~hwPrev;
  assign hwFall  = ~hwS & hwPrev;
  assign gapDone = (gapCnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwPrev <= 1'b1;
      gapCnt <= CNT_MAX;
      armed  <= 1'b0;
    end else begin
      hwPrev <= hwS;
      if (hwRise) begin
        gapCnt <= '0;
        armed  <= faultLatched & gapDone;
      end else begin
        if (!gapDone) gapCnt <= gapCnt + 1'b1;
        if (hwFall) armed <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.setFault = faultS;
    strobes.clrFault = hwFall & armed;
    strobes.hwDis    = hwS;
  end

  // R6: a clear is only ever issued against a latched fault
  p_clear_only_latched_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrFault |-> faultLatched);

  // R8: arming happens only once the spacing window has run out
  p_arm_spacing_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(gapCnt) == CNT_MAX);
endmodule

// File: rtl/laser_guard_dp.sv
module laser_guard_dp
  import laser_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  input  logic          regWrEn,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  output logic          faultLatched,
  output logic          laserEnable,
  output logic          txFaultOut
);
  logic swDis;
  logic faultQ;
  logic effDis;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swDis  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      if (regWrEn) swDis <= regWrData[BIT_SWDIS];
      if (strobes.setFault)      faultQ <= 1'b1;
      else if (strobes.clrFault) faultQ <= 1'b0;
    end
  end

  assign effDis       = strobes.hwDis | swDis;
  assign laserEnable  = ~effDis & ~faultQ;
  assign txFaultOut   = faultQ;
  assign faultLatched = faultQ;

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_MON]   = effDis;
    regRdData[BIT_SWDIS] = swDis;
    regRdData[BIT_FAULT] = faultQ;
  end

  // R10: a fault seen by the control wins over a clear in the same cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFault |=> faultQ);

  // R5: without a clear strobe the latch holds
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultQ && !strobes.clrFault |=> faultQ);

  // R9: the software bit moves only on a write
  p_wr_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(swDis));
endmodule

// File: rtl/laser_guard.sv
module laser_guard
  import laser_guard_pkg::*;
#(
  parameter int SPACING_CYCLES = 1250000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwDisableIn,
  input  logic       faultDetectIn,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       laserEnable,
  output logic       txFaultOut
);
  guardStrobes_t strobes;
  logic          faultLatched;

  laser_guard_ctrl #(
    .SPACING_CYCLES(SPACING_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .hwDisableIn  (hwDisableIn),
    .faultDetectIn(faultDetectIn),
    .faultLatched (faultLatched),
    .strobes      (strobes)
  );

  laser_guard_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .faultLatched(faultLatched),
    .laserEnable (laserEnable),
    .txFaultOut  (txFaultOut)
  );

  // R4: a latched fault keeps the laser dark
  p_fault_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    txFaultOut |-> !laserEnable);

  // R2: software disable keeps the laser dark
  p_sw_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BIT_SWDIS] |-> !laserEnable);

  // R11: the status byte tracks the fault pin
  p_fault_mirror_r11: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BIT_FAULT] == txFaultOut);
endmodule

// File: tb/laser_guard_tb_top.sv
module laser_guard_tb_top;
  localparam int SPACING = 40;
  localparam int NSTEP   = 23;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hwDisableIn = 1'b1;
  logic       faultDetectIn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       laserEnable;
  logic       txFaultOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  laser_guard #(.SPACING_CYCLES(SPACING)) dut_i (
    .clk(clk), .rstN(rstN), .hwDisableIn(hwDisableIn),
    .faultDetectIn(faultDetectIn), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .laserEnable(laserEnable), .txFaultOut(txFaultOut)
  );

  // hw, fault, wr, wdata, wait, expEn, expFault, expRd
  localparam logic [28:0] TABLE [0:NSTEP-1] = '{
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b1,1'b0,8'h00},
    {1'b0,1'b0,1'b1,8'h40,8'd10,1'b0,1'b0,8'hC0},
    {1'b0,1'b0,1'b1,8'h00,8'd10,1'b1,1'b0,8'h00},
    {1'b0,1'b0,1'b1,8'hFF,8'd10,1'b0,1'b0,8'hC0},
    {1'b0,1'b0,1'b1,8'h00,8'd10,1'b1,1'b0,8'h00},
    {1'b1,1'b0,1'b0,8'h00,8'd10,1'b0,1'b0,8'h80},
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b1,1'b0,8'h00},
    {1'b0,1'b1,1'b0,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b0,1'b0,1'b1,8'h40,8'd10,1'b0,1'b1,8'hC4},
    {1'b0,1'b0,1'b1,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b1,1'b0,1'b0,8'h00,8'd5, 1'b0,1'b1,8'h84},
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b1,1'b0,8'h00},
    {1'b0,1'b1,1'b0,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b1,1'b0,1'b0,8'h00,8'd10,1'b0,1'b1,8'h84},
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b0,1'b0,1'b0,8'h00,8'd50,1'b0,1'b1,8'h04},
    {1'b1,1'b0,1'b0,8'h00,8'd10,1'b0,1'b1,8'h84},
    {1'b0,1'b1,1'b0,8'h00,8'd10,1'b0,1'b1,8'h04},
    {1'b0,1'b0,1'b0,8'h00,8'd50,1'b0,1'b1,8'h04},
    {1'b1,1'b0,1'b0,8'h00,8'd10,1'b0,1'b1,8'h84},
    {1'b0,1'b0,1'b0,8'h00,8'd10,1'b1,1'b0,8'h00}
  };

  function automatic string stepTag(int i);
    case (i)
      0, 5:         return "R1";
      1, 2:         return "R2";
      6:            return "R3";
      3, 4:         return "R9";
      7, 13:        return "R4";
      8, 9, 14:     return "R5";
      10:           return "R11";
      15, 16, 17:   return "R8";
      19, 20:       return "R10";
      default:      return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic en, logic tf, logic [7:0] rd);
    nChk++;
    if (laserEnable !== en || txFaultOut !== tf || regRdData !== rd) begin
      nBad++;
      $display("FAIL %s: actual en=%0b fault=%0b rd=%02h expected en=%0b fault=%0b rd=%02h",
               tag, laserEnable, txFaultOut, regRdData, en, tf, rd);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R7: reset state with the pin still high
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", 1'b0, 1'b0, 8'h80);
    repeat (4) @(negedge clk);
    check("R7", 1'b0, 1'b0, 8'h80);

    for (int i = 0; i < NSTEP; i++) begin
      logic [28:0] v;
      v = TABLE[i];
      hwDisableIn   = v[28];
      faultDetectIn = v[27];
      regWrEn       = v[26];
      regWrData     = v[25:18];
      @(negedge clk);
      regWrEn = 1'b0;
      repeat (int'(v[17:10]) - 1) @(negedge clk);
      check(stepTag(i), v[9], v[8], v[7:0]);
    end

    // R7: reset clears a latched fault and the software bit
    regWrEn = 1'b1; regWrData = 8'h40;
    @(negedge clk);
    regWrEn = 1'b0;
    faultDetectIn = 1'b1;
    repeat (6) @(negedge clk);
    faultDetectIn = 1'b0;
    check("R4", 1'b0, 1'b1, 8'hC4);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", 1'b0, 1'b0, 8'h80);
    repeat (5) @(negedge clk);
    check("R7", 1'b1, 1'b0, 8'h00);

    finishRun();
  end
endmodule